// File: doc/BRIEF.md
# Switch Port Output Mode Mapper

This block drives the eight switch control pins of a satellite LNB or switcher. It takes four committed control bits (band, polarisation, satellite position, switch option) and four uncommitted switch bits. A configuration byte then decides how those eight bits reach the eight output pins. The pins can follow the bits one for one. They can show the group of four committed bits beside its inverse. They can also act as a demultiplexer, where a window of adjacent control lines selects a single active pin. The window is three lines wide for a 1-of-8 choice, or two lines for a 1-of-4 choice.

The configuration byte is held steady by the surrounding logic. The control bits change whenever a command or a backwards-compatible line condition updates them. The mapper recomputes the pin pattern from the current inputs and registers it, so every pin changes on one clock edge.

Top module: `swmap_port`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, `op_o` is 8'h00. The reset takes effect without a clock edge. After `rst_n` rises, the output stays 0 for two further rising edges, until the internal release has passed its synchroniser.
- R2: Direct mode applies when no decoded mode is active and config bit 5 is 0. In this mode `op_o[3:0]` equals `com_i[3:0]` and `op_o[7:4]` equals `unc_i[3:0]`. The committed bits are ordered bit 0 = band (Hi/Lo), bit 1 = polarisation (H/V), bit 2 = position (SB/SA), bit 3 = option (SO B/A). The uncommitted bits run from switch 5 in bit 0 to switch 8 in bit 3.
- R3: Complementary mode applies when config bit 5 is 1 and no decoded mode is active. In this mode `op_o[3:0]` equals `com_i`, and `op_o[7:4]` equals `~com_i`.
- R4: A decoded mode is active when config bits 4:1 hold a number n from 1 to 8. The control lines form the vector L = {unc_i, com_i}, with line 0 as its LSB. The three lines L[n-1], L[n], L[n+1] form a code with L[n-1] as its LSB. Exactly one bit of `op_o` is high, at the position given by that code.
- R5: The line window wraps modulo 8. For n = 7 the window is lines 6, 7, 0. For n = 8 it is lines 7, 0, 1.
- R6: When a decoded mode is active and config bit 6 is 1, the lowest line of the window counts as 0. Exactly one output is high, and it is always one of bits 0, 2, 4 or 6.
- R7: When a decoded mode is active, config bit 5 has no effect. Decoded mode takes priority over complementary mode.
- R8: Config bits 7 and 0 have no effect on `op_o`. Config bit 6 has no effect when no decoded mode is active.
- R9: Values 9 to 15 in config bits 4:1 count as no decoded mode. The block then follows R2 or R3.
- R10: `op_o` is registered. A change at the inputs shows up only after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| com_i | input | 4 | Committed control bits: band, polarisation, position, option |
| unc_i | input | 4 | Uncommitted switch bits 5 to 8 |
| cfg_i | input | 8 | Mapping configuration byte |
| op_o | output | 8 | Registered switch pin pattern, bit 0 = first pin |

## Verification
The bench applies every combination of configuration byte, committed bits and uncommitted bits, so every window start, both wrap positions and every mode conflict are covered.

- A window that fails to wrap would read the wrong line for mode numbers 7 and 8, or index past the vector.
- A design that ranks complementary mode above decoded mode would drive the inverted half instead of a single active pin.
- A mask on the wrong end of the window would make odd outputs reachable in 1-of-4 mode.
- Decoding mode numbers 9 to 15 would turn out single-pin patterns where the direct or complementary pattern is expected.
- For each vector, the output is also checked just before the clock edge. This catches a path that bypasses the register.

// File: rtl/swmap_pkg.sv
package swmap_pkg;

  // Mapping applied to the switch pins
  typedef enum logic [1:0] {
    MAP_DIRECT = 2'd0,
    MAP_COMPL  = 2'd1,
    MAP_DEC3   = 2'd2,
    MAP_DEC2   = 2'd3
  } map_mode_e;

  // Configuration byte field positions (decoded by the mapper and its checker)
  localparam int unsigned CFG_W       = 8;
  localparam int unsigned CFG_NUM_LSB = 1;
  localparam int unsigned CFG_NUM_W   = 4;
  localparam int unsigned CFG_CMP_BIT = 5;
  localparam int unsigned CFG_TWO_BIT = 6;

endpackage

// File: rtl/swmap_rst_sync.sv
module swmap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/swmap_cfg_decode.sv
module swmap_cfg_decode
  import swmap_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned SEL_W = $clog2(PORT_W)
) (
  input  logic [CFG_NUM_W-1:0] num_i,
  input  logic                 cmp_i,
  input  logic                 two_i,
  output map_mode_e            mode_o,
  output logic [SEL_W-1:0]     start_o
);

  // Largest legal decoded-mode number equals the number of control lines
  localparam logic [CFG_NUM_W:0] NUM_MAX = (CFG_NUM_W+1)'(PORT_W);

  logic dec_on;

  always_comb begin
    dec_on  = (num_i != '0) && ({1'b0, num_i} <= NUM_MAX);
    // Window starts at line n-1; the narrow cast wraps n = PORT_W to the top line
    start_o = SEL_W'(num_i) - SEL_W'(1);
    if (dec_on) begin
      mode_o = two_i ? MAP_DEC2 : MAP_DEC3;
    end else if (cmp_i) begin
      mode_o = MAP_COMPL;
    end else begin
      mode_o = MAP_DIRECT;
    end
  end

endmodule

// File: rtl/swmap_line_pick.sv
module swmap_line_pick #(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned SEL_W = $clog2(PORT_W)
) (
  input  logic [PORT_W-1:0] lines_i,
  input  logic [SEL_W-1:0]  start_i,
  input  logic              drop_low_i,
  output logic [SEL_W-1:0]  code_o
);

  logic [SEL_W-1:0] pick;

  // PORT_W is a power of two, so SEL_W-bit addition wraps around the lines
  for (genvar k = 0; k < SEL_W; k++) begin : g_tap
    logic [SEL_W-1:0] pos;
    assign pos     = start_i + SEL_W'(k);
    assign pick[k] = lines_i[pos];
  end

  always_comb begin
    code_o    = pick;
    code_o[0] = pick[0] & ~drop_low_i;
  end

endmodule

// File: rtl/swmap_demux.sv
module swmap_demux #(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned SEL_W = $clog2(PORT_W)
) (
  input  logic [SEL_W-1:0]  code_i,
  output logic [PORT_W-1:0] hot_o
);

  for (genvar k = 0; k < PORT_W; k++) begin : g_out
    assign hot_o[k] = (code_i == SEL_W'(k));
  end

endmodule

// File: rtl/swmap_port.sv
module swmap_port
  import swmap_pkg::*;
#(
  parameter int unsigned GRP_W = 4,
  localparam int unsigned PORT_W = 2 * GRP_W,
  localparam int unsigned SEL_W  = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  com_i,
  input  logic [GRP_W-1:0]  unc_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [PORT_W-1:0] op_o
);

  logic              rst_q_n;
  logic [PORT_W-1:0] lines;
  map_mode_e         mode;
  logic [SEL_W-1:0]  start;
  logic [SEL_W-1:0]  code;
  logic [PORT_W-1:0] hot;
  logic [PORT_W-1:0] op_d;
  logic [PORT_W-1:0] op_q;
  logic              upd_en;
  logic              unused_cfg;

  // Bits outside the mapping fields are deliberately ignored
  assign unused_cfg = ^{cfg_i[CFG_W-1], cfg_i[0]};

  assign lines = {unc_i, com_i};

  swmap_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  swmap_cfg_decode #(.PORT_W(PORT_W)) u_dec (
    .num_i   (cfg_i[CFG_NUM_LSB +: CFG_NUM_W]),
    .cmp_i   (cfg_i[CFG_CMP_BIT]),
    .two_i   (cfg_i[CFG_TWO_BIT]),
    .mode_o  (mode),
    .start_o (start)
  );

  swmap_line_pick #(.PORT_W(PORT_W)) u_pick (
    .lines_i    (lines),
    .start_i    (start),
    .drop_low_i (mode == MAP_DEC2),
    .code_o     (code)
  );

  swmap_demux #(.PORT_W(PORT_W)) u_demux (
    .code_i (code),
    .hot_o  (hot)
  );

  // Next-state selection
  always_comb begin
    unique case (mode)
      MAP_DEC3, MAP_DEC2: op_d = hot;
      MAP_COMPL:          op_d = {~com_i, com_i};
      default:            op_d = lines;
    endcase
    upd_en = (op_d != op_q);
  end

  // Output register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      op_q <= '0;
    end else if (upd_en) begin
      op_q <= op_d;
    end
  end

  assign op_o = op_q;

endmodule

// File: rtl/swmap_port_chk.sv
module swmap_port_chk
  import swmap_pkg::*;
#(
  parameter int unsigned GRP_W = 4,
  localparam int unsigned PORT_W = 2 * GRP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GRP_W-1:0]  com_i,
  input logic [GRP_W-1:0]  unc_i,
  input logic [CFG_W-1:0]  cfg_i,
  input logic [PORT_W-1:0] op_o
);

  function automatic logic [PORT_W-1:0] odd_mask();
    logic [PORT_W-1:0] m;
    for (int i = 0; i < PORT_W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [PORT_W-1:0] ODD_M = odd_mask();

  logic [CFG_NUM_W-1:0] n_fld;
  logic dec_act;
  logic two_act;
  logic cmp_act;
  logic dir_act;
  logic [GRP_W*2+CFG_W-1:0] in_all;

  always_comb begin
    n_fld   = cfg_i[CFG_NUM_LSB +: CFG_NUM_W];
    dec_act = (n_fld >= 1) && (int'(n_fld) <= PORT_W);
    two_act = dec_act && cfg_i[CFG_TWO_BIT];
    cmp_act = !dec_act && cfg_i[CFG_CMP_BIT];
    dir_act = !dec_act && !cfg_i[CFG_CMP_BIT];
    in_all  = {cfg_i, unc_i, com_i};
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_zero_chk: assert (op_o == '0);
    end
  end

  // R4
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dec_act)) |-> ($countones(op_o) == 1));

  // R6
  two_line_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(two_act)) |-> ((op_o & ODD_M) == '0));

  // R3
  compl_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmp_act)) |->
      (op_o == {~$past(com_i), $past(com_i)}));

  // R2
  direct_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dir_act)) |-> (op_o == $past({unc_i, com_i})));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && ($past(in_all) == $past(in_all, 2)))
      |-> $stable(op_o));

endmodule

bind swmap_port swmap_port_chk #(.GRP_W(GRP_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .com_i (com_i),
  .unc_i (unc_i),
  .cfg_i (cfg_i),
  .op_o  (op_o)
);

// File: tb/swmap_port_tb.sv
module swmap_port_tb;

  logic       clk;
  logic       rst_n;
  logic [3:0] com_i;
  logic [3:0] unc_i;
  logic [7:0] cfg_i;
  logic [7:0] op_o;

  int checks;
  int fails;
  logic [7:0] prev_exp;

  swmap_port u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .com_i (com_i),
    .unc_i (unc_i),
    .cfg_i (cfg_i),
    .op_o  (op_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] model(logic [3:0] c, logic [3:0] u, logic [7:0] g);
    logic [7:0] v;
    int n, s, idx;
    v = {u, c};
    n = int'(g[4:1]);
    if (n >= 1 && n <= 8) begin
      s   = n - 1;
      idx = 4 * int'(v[(s + 2) % 8]) + 2 * int'(v[(s + 1) % 8]);
      if (!g[6]) idx = idx + int'(v[s % 8]);
      return 8'(1 << idx);
    end else if (g[5]) begin
      return {~c, c};
    end
    return v;
  endfunction

  function automatic string tag_of(logic [7:0] g);
    int n;
    n = int'(g[4:1]);
    if (n >= 1 && n <= 8) begin
      if (g[5])      return "R7";
      if (g[6])      return "R6";
      if (n >= 7)    return "R5";
      return "R4";
    end
    if (n > 8)             return "R9";
    if (g[7] || g[0] || g[6]) return "R8";
    if (g[5])              return "R3";
    return "R2";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: op_o=%h expected=%h (com=%h unc=%h cfg=%h)",
               req, act, exp, com_i, unc_i, cfg_i);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    com_i  = 4'h5;
    unc_i  = 4'hA;
    cfg_i  = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", op_o, 8'h00);
    rst_n = 1'b1;
    // synchroniser: output still held on the first release edges
    @(negedge clk);
    check("R1", op_o, 8'h00);
    repeat (3) @(negedge clk);
    check("R2", op_o, 8'hA5);

    // asynchronous reset mid-run, observed before any clock edge
    #2 rst_n = 1'b0;
    #1 check("R1", op_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    prev_exp = model(com_i, unc_i, cfg_i);
    check("R2", op_o, prev_exp);

    for (int g = 0; g < 256; g++) begin
      for (int c = 0; c < 16; c++) begin
        for (int u = 0; u < 16; u++) begin
          logic [7:0] e;
          com_i = 4'(c);
          unc_i = 4'(u);
          cfg_i = 8'(g);
          e = model(4'(c), 4'(u), 8'(g));
          #2 check("R10", op_o, prev_exp);
          @(negedge clk);
          check(tag_of(8'(g)), op_o, e);
          prev_exp = e;
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule